// File: doc/BRIEF.md
# Tamper Detect and Memory Clear Controller

This block guards a small on-chip scratch memory against physical intrusion. It watches two contact-sense inputs, one per channel. Each channel is set up on its own: it can be switched on or off, told whether its contact normally rests open or closed, and told which rail (ground or supply) the contact connects to. Every input is first synchronized and debounced. Once a channel sees a qualifying event, it raises a sticky flag and saves the current value of a free-running seconds counter as a timestamp.

If the triggering channel also has its clear request set, the block erases the 128-byte memory, writing zero to one address per clock. It also raises a clear output for a programmable number of seconds, which an external supply-cutoff circuit can use. A one-second tick input sets the pace of both the seconds counter and the pulse timer.

A host reaches the memory, the per-channel settings, the status and the timestamps through one flat byte address space. Writes take effect on the next clock. Read data returns two cycles after the request.

Top module: `tamper_guard`

## Requirements
- R1: After reset the clear output is low, every status bit reads zero, both timestamps read zero and the seconds counter starts from zero.
- R2: Address bit 7 low selects memory byte addr[6:0]. Address bit 7 high selects registers: 0x80/0x81 channel 0/1 settings, 0x82 status, 0x83 pulse-width code (bits 1:0), 0x84..0x87 channel 0 timestamp and 0x88..0x8B channel 1 timestamp, least significant byte first. Read data appears with rd_valid_o two cycles after rd_en_i.
- R3: In a channel settings byte, bit 0 enables the channel, bit 1 requests a clear, bit 2 selects normally closed (1) or normally open (0), and bit 3 selects a contact to supply (1) or to ground (0). The contact counts as closed when the input equals the rail level. An event is a closed contact in normally-open mode or an open contact in normally-closed mode. A disabled channel never flags.
- R4: An input level is accepted only after it has been steady for 3 synchronized cycles. A glitch of 2 cycles sets no flag.
- R5: Status bits 1:0 are the channel flags. A flag and its timestamp are latched on the first event only. Later events do not change them until the host writes 1 to that flag bit at 0x82.
- R6: An event on an enabled channel whose clear bit is set starts a memory wipe and raises the clear output. An event on a channel without the clear bit starts neither.
- R7: The wipe zeroes addresses 0 to 127, one per clock. While the wipe runs, status bit 3 is set, host memory writes are dropped and memory reads return zero. At the end, status bit 2 (wipe done) is set. Writing 1 to bit 2 clears it.
- R8: Pulse-width codes 00, 01, 10 and 11 hold the clear output high for 1, 4, 8 and 16 ticks. It falls on the last of those ticks. Status bit 4 mirrors the clear output.
- R9: An event that arrives while the clear output is high neither restarts nor lengthens the pulse.
- R10: Events on both channels in the same cycle set both flags with the same timestamp and produce a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sec_tick_i | input | 1 | One-cycle pulse once per second |
| tamper_i | input | 2 | Raw contact-sense inputs, bit n for channel n |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read request |
| addr_i | input | 8 | Host byte address |
| wr_data_i | input | 8 | Host write data |
| rd_data_o | output | 8 | Host read data |
| rd_valid_o | output | 1 | Read data valid, two cycles after rd_en_i |
| clr_o | output | 1 | Timed clear output, high during the clear pulse |

## Verification
The bench drives a 2-cycle glitch that must be filtered out. A filter that is too short would flag a tamper from contact bounce. It clears a flag while the contact is still active, so the event re-arms in the middle of a running pulse. A timer that restarts would hold the clear output past its fourth tick. It reads the top memory byte early in a wipe, before the wipe has reached it. A design without read blanking would return the stale byte. It also fires both channels in the same cycle and checks for one 16-tick pulse and matching timestamps. A second re-arm would show up as a longer pulse.

// File: rtl/tamper_pkg.sv
package tamper_pkg;

  localparam int NCH = 2;

  // bit 0 enable, bit 1 clear request, bit 2 normally-closed, bit 3 supply rail
  typedef struct packed {
    logic rail_vcc;
    logic norm_closed;
    logic clr_req;
    logic enable;
  } chan_cfg_t;

  function automatic logic [4:0] pulse_len(input logic [1:0] code);
    case (code)
      2'b00:   return 5'd1;
      2'b01:   return 5'd4;
      2'b10:   return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/tamper_input_filter.sv
module tamper_input_filter #(
  parameter int DEB_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pin_i,
  output logic level_o
);

  logic [1:0]         sync_q;
  logic [DEB_CYC-1:0] hist_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q  <= '0;
      hist_q  <= '0;
      level_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      hist_q <= {hist_q[DEB_CYC-2:0], sync_q[1]};
      if (&hist_q)       level_o <= 1'b1;
      else if (~|hist_q) level_o <= 1'b0;
    end
  end

  AST_DEB_RISE_STEADY: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(level_o) |-> ($past(sync_q[1], 2) && $past(sync_q[1], 3) && $past(sync_q[1], 4))); // R4

endmodule

// File: rtl/tamper_pulse_timer.sv
module tamper_pulse_timer
  import tamper_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       start_i,
  input  logic [1:0] width_i,
  input  logic       tick_i,
  output logic       active_o
);

  logic [4:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (active_o) begin
      if (tick_i) begin
        cnt_q <= cnt_q - 5'd1;
        if (cnt_q == 5'd1) active_o <= 1'b0;
      end
    end else if (start_i) begin
      active_o <= 1'b1;
      cnt_q    <= pulse_len(width_i);
    end
  end

  AST_PULSE_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(active_o) |-> $past(start_i)); // R6
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
    (active_o && start_i && !tick_i) |=> (cnt_q == $past(cnt_q))); // R9
  AST_PULSE_COUNT_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    active_o |-> (cnt_q != 5'd0 && cnt_q <= 5'd16)); // R8

endmodule

// File: rtl/tamper_wipe_ram.sv
module tamper_wipe_ram #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              host_we_i,
  input  logic [AW-1:0]     host_waddr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              finish_o
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     ptr_q;
  logic              we;
  logic [AW-1:0]     waddr;
  logic [DATA_W-1:0] wdata;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_o   <= 1'b0;
      ptr_q    <= '0;
      finish_o <= 1'b0;
    end else begin
      finish_o <= 1'b0;
      if (busy_o) begin
        ptr_q <= ptr_q + 1'b1;
        if (ptr_q == AW'(DEPTH - 1)) begin
          busy_o   <= 1'b0;
          finish_o <= 1'b1;
        end
      end else if (start_i) begin
        busy_o <= 1'b1;
        ptr_q  <= '0;
      end
    end
  end

  always_comb begin
    we    = busy_o | host_we_i;
    waddr = busy_o ? ptr_q : host_waddr_i;
    wdata = busy_o ? '0 : host_wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (we) mem[waddr] <= wdata;
    rdata_o <= mem[raddr_i];
  end

  AST_WIPE_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && $past(busy_o)) |-> (ptr_q == $past(ptr_q) + 1'b1)); // R7
  AST_WIPE_FINISH_AT_TOP: assert property (@(posedge clk_i) disable iff (rst_i)
    finish_o |-> (!busy_o && $past(ptr_q) == AW'(DEPTH - 1))); // R7

endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
  import tamper_pkg::*;
#(
  parameter int RAM_DEPTH = 128,
  parameter int DATA_W    = 8,
  parameter int TS_W      = 32,
  parameter int DEB_CYC   = 3,
  localparam int RAM_AW   = $clog2(RAM_DEPTH),
  localparam int HAW      = RAM_AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              sec_tick_i,
  input  logic [NCH-1:0]    tamper_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [HAW-1:0]    addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              clr_o
);

  localparam int TS_BYTES = TS_W / 8;
  localparam int REG_STAT = 2;
  localparam int REG_WID  = 3;
  localparam int REG_TS   = 4;

  chan_cfg_t         cfg_q [NCH];
  logic [1:0]        width_q;
  logic [NCH-1:0]    flag_q, filt, evt, new_evt;
  logic [TS_W-1:0]   ts_q [NCH];
  logic [TS_W-1:0]   sec_q;
  logic              done_q, start, wipe_busy, wipe_finish;
  logic              reg_sel, reg_wr, stat_wr;
  logic [RAM_AW-1:0] idx;
  logic [DATA_W-1:0] reg_rdata, ram_rdata, reg_rd_q;
  logic              rv1_q, is_ram_q, blank_q;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    tamper_input_filter #(.DEB_CYC(DEB_CYC)) u_filt (
      .clk_i(clk_i), .rst_i(rst_i), .pin_i(tamper_i[g]), .level_o(filt[g]));

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
      (flag_q[g] && !(stat_wr && wr_data_i[g])) |=> (flag_q[g] && $stable(ts_q[g]))); // R5
  end

  always_comb begin
    reg_sel = addr_i[HAW-1];
    idx     = addr_i[RAM_AW-1:0];
    reg_wr  = wr_en_i & reg_sel;
    stat_wr = reg_wr & (idx == RAM_AW'(REG_STAT));
    start   = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      evt[i]     = cfg_q[i].enable &
                   ((filt[i] ~^ cfg_q[i].rail_vcc) ^ cfg_q[i].norm_closed);
      new_evt[i] = evt[i] & ~flag_q[i];
      start      = start | (new_evt[i] & cfg_q[i].clr_req);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sec_q   <= '0;
      flag_q  <= '0;
      done_q  <= 1'b0;
      width_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        cfg_q[i] <= '0;
        ts_q[i]  <= '0;
      end
    end else begin
      if (sec_tick_i) sec_q <= sec_q + 1'b1;
      for (int i = 0; i < NCH; i++) begin
        if (reg_wr && idx == RAM_AW'(i)) cfg_q[i] <= chan_cfg_t'(wr_data_i[3:0]);
        if (new_evt[i]) begin
          flag_q[i] <= 1'b1;
          ts_q[i]   <= sec_q;
        end else if (stat_wr && wr_data_i[i]) begin
          flag_q[i] <= 1'b0;
        end
      end
      if (reg_wr && idx == RAM_AW'(REG_WID)) width_q <= wr_data_i[1:0];
      if (wipe_finish)                       done_q <= 1'b1;
      else if (start)                        done_q <= 1'b0;
      else if (stat_wr && wr_data_i[NCH])    done_q <= 1'b0;
    end
  end

  tamper_wipe_ram #(.DEPTH(RAM_DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start),
    .host_we_i(wr_en_i & ~reg_sel), .host_waddr_i(idx), .host_wdata_i(wr_data_i),
    .raddr_i(idx), .rdata_o(ram_rdata), .busy_o(wipe_busy), .finish_o(wipe_finish));

  tamper_pulse_timer u_timer (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start), .width_i(width_q),
    .tick_i(sec_tick_i), .active_o(clr_o));

  always_comb begin
    reg_rdata = '0;
    if (idx < RAM_AW'(NCH))              reg_rdata = DATA_W'(cfg_q[idx[0]]);
    else if (idx == RAM_AW'(REG_STAT))   reg_rdata = DATA_W'({clr_o, wipe_busy, done_q, flag_q});
    else if (idx == RAM_AW'(REG_WID))    reg_rdata = DATA_W'(width_q);
    for (int c = 0; c < NCH; c++)
      for (int b = 0; b < TS_BYTES; b++)
        if (idx == RAM_AW'(REG_TS + c * TS_BYTES + b))
          reg_rdata = DATA_W'(ts_q[c][8*b +: 8]);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rv1_q      <= 1'b0;
      is_ram_q   <= 1'b0;
      blank_q    <= 1'b0;
      reg_rd_q   <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rv1_q      <= rd_en_i;
      is_ram_q   <= ~reg_sel;
      blank_q    <= wipe_busy;
      reg_rd_q   <= reg_rdata;
      rd_valid_o <= rv1_q;
      rd_data_o  <= is_ram_q ? (blank_q ? '0 : ram_rdata) : reg_rd_q;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rd_en_i, 2) |-> rd_valid_o); // R2
  AST_NO_CLEAR_WITHOUT_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(wipe_busy) |-> $past(|(new_evt & {cfg_q[1].clr_req, cfg_q[0].clr_req}))); // R6

endmodule

// File: tb/test_tamper_guard.sv
`timescale 1ns/1ps
module test_tamper_guard;

  logic       clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic [1:0] tmp = 2'b01;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rd_data;
  logic       rd_valid, clr;

  typedef struct { logic [7:0] exp; string req; } item_t;
  item_t sb[$];
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tamper_guard i_tamper_guard (
    .clk_i(clk), .rst_i(rst), .sec_tick_i(tick), .tamper_i(tmp),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wr_data_i(wdata),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .clr_o(clr));

  // monitor: pops scoreboard entries as read data comes back
  always @(negedge clk) begin
    item_t it;
    if (!rst && rd_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected read data: actual=%h expected=none", rd_data);
      end else begin
        it = sb.pop_front();
        if (rd_data !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", it.req, rd_data, it.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string req);
    item_t it;
    it.exp = e; it.req = req;
    sb.push_back(it);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    idle(3);
  endtask

  task automatic tk();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    idle(3);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(10);
    // R1 reset state
    chk("R1 clear output after reset", clr, 0);
    rd(8'h82, 8'h00, "R1 status after reset");
    rd(8'h84, 8'h00, "R1 timestamp0 after reset");
    // R2 memory and register access
    wr(8'h00, 8'h5A); wr(8'h05, 8'hC3); wr(8'h7F, 8'h81);
    rd(8'h00, 8'h5A, "R2 ram addr 0");
    rd(8'h05, 8'hC3, "R2 ram addr 5");
    rd(8'h7F, 8'h81, "R2 ram addr 127");
    // R3 channel setup: ch0 normally-open to ground, ch1 normally-closed to ground, no clear
    wr(8'h83, 8'h01);
    wr(8'h80, 8'h03);
    wr(8'h81, 8'h05);
    rd(8'h81, 8'h05, "R2 settings readback");
    tk(); tk(); tk();                      // seconds = 3
    // R4 two-cycle glitch on ch0
    @(negedge clk); tmp[0] = 1'b0;
    idle(2); tmp[0] = 1'b1;
    idle(12);
    rd(8'h82, 8'h00, "R4 glitch filtered");
    // R3 / R6 ch1 contact opens: flag, no clear
    @(negedge clk); tmp[1] = 1'b1;
    idle(12);
    rd(8'h82, 8'h02, "R3 ch1 normally-closed event flag");
    rd(8'h88, 8'h03, "R5 ch1 timestamp");
    chk("R6 no pulse without clear bit", clr, 0);
    rd(8'h05, 8'hC3, "R6 no wipe without clear bit");
    tmp[1] = 1'b0;
    tk(); tk();                            // seconds = 5
    // R6 / R7 ch0 contact closes with clear bit
    @(negedge clk); tmp[0] = 1'b0;
    idle(10);
    chk("R6 clear output raised", clr, 1);
    rd(8'h7F, 8'h00, "R7 read blanked during wipe");
    idle(200);
    rd(8'h7F, 8'h00, "R7 top byte wiped");
    rd(8'h00, 8'h00, "R7 bottom byte wiped");
    rd(8'h82, 8'h17, "R7 status flags done pulse");
    rd(8'h84, 8'h05, "R5 ch0 timestamp");
    // R8 / R9 four-tick pulse with re-arm while active
    tk(); chk("R8 high after tick 1", clr, 1);
    tk(); chk("R8 high after tick 2", clr, 1);   // seconds = 7
    wr(8'h82, 8'h01);                            // clear flag0 while contact still closed
    idle(4);
    tk(); chk("R9 high after tick 3", clr, 1);
    tk(); chk("R9 low after tick 4, no restart", clr, 0);   // seconds = 9
    rd(8'h84, 8'h07, "R5 ch0 re-armed timestamp");
    @(negedge clk); tmp[1] = 1'b1;               // ch1 event while flagged
    idle(12);
    rd(8'h88, 8'h03, "R5 ch1 timestamp kept on later event");
    idle(200);
    rd(8'h82, 8'h07, "R8 status after pulse end");
    // R10 simultaneous events, 16-tick pulse
    wr(8'h81, 8'h07);
    wr(8'h83, 8'h03);
    @(negedge clk); tmp = 2'b01;
    idle(20);
    wr(8'h82, 8'h07);
    idle(10);
    rd(8'h82, 8'h00, "R5 write-one clears flags and done");
    @(negedge clk); tmp = 2'b10;
    idle(12);
    chk("R10 pulse started", clr, 1);
    idle(200);
    rd(8'h82, 8'h17, "R10 both flags one wipe");
    rd(8'h84, 8'h09, "R10 ch0 timestamp");
    rd(8'h88, 8'h09, "R10 ch1 timestamp");
    for (int i = 0; i < 15; i++) tk();
    chk("R8 width 11 high after 15 ticks", clr, 1);
    tk();
    chk("R8 width 11 low after 16 ticks", clr, 0);
    // R3 disabled channel ignores an active contact
    wr(8'h80, 8'h00);
    @(negedge clk); tmp[1] = 1'b0;
    idle(12);
    wr(8'h82, 8'h07);
    idle(20);
    rd(8'h82, 8'h00, "R3 disabled channel sets no flag");
    chk("R3 disabled channel no pulse", clr, 0);
    idle(10);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 missing read responses: actual=%0d expected=0", sb.size());
    end
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule